// File: doc/BRIEF.md
# Byte Shift-Rotate Unit with Flags

This block is a purely combinational 8-bit shifter for a small 8-bit processor datapath. It takes one operand byte, the current flag byte and a three-bit operation code. It returns the shifted or rotated byte and the new flag byte in the same cycle. It has four rotates (circular in both directions, and through carry in both directions) and three shifts (arithmetic left, arithmetic right and logical right).

A separate select asks for the short accumulator form of a rotate. In that form the result byte is the same, but only the carry changes. Sign, zero and parity keep their incoming values, and the two cleared flags are still cleared. The full forms, and every shift, rewrite the whole flag set, with even parity of the result on the parity/overflow bit. Any other operation code returns the operand and the flags untouched.

The flag byte layout is S at bit 7, Z at bit 6, H at bit 4, P/V at bit 2, N at bit 1 and C at bit 0. Bits 5 and 3 are spare and are carried through unchanged.

Top module: `shr_unit`

## Requirements
- R1: Op code 0 (circular left) gives result {a[6:0],a[7]} and sets C to a[7].
- R2: Op code 1 (circular right) gives result {a[0],a[7:1]} and sets C to a[0].
- R3: Op code 2 (left through carry) gives result {a[6:0],Cin} and sets C to a[7], where Cin is flags_i bit 0.
- R4: Op code 3 (right through carry) gives result {Cin,a[7:1]} and sets C to a[0].
- R5: Op code 4 (arithmetic left) gives result {a[6:0],1'b0} and sets C to a[7].
- R6: Op code 5 (arithmetic right) gives result {a[7],a[7:1]} and sets C to a[0].
- R7: Op code 6 (logical right) gives result {1'b0,a[7:1]} and sets C to a[0].
- R8: In the full form of op codes 0 to 6, flags_o bit 7 (S) equals result bit 7 and bit 6 (Z) is 1 exactly when the result is zero. Bit 2 (P/V) is 1 exactly when the result has an even number of ones. Bit 4 (H) and bit 1 (N) are 0.
- R9: With short_i high and op codes 0 to 3, the result is the same as in the full form and C is updated. H and N are 0, and S, Z and P/V equal their incoming values.
- R10: For op codes 4 to 6, short_i has no effect on the result or on the flags.
- R11: Op code 7 returns the operand unchanged as the result and returns flags_i unchanged as flags_o.
- R12: Bits 5 and 3 of flags_o always equal bits 5 and 3 of flags_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_i | input | 8 | Operand byte |
| flags_i | input | 8 | Incoming flag byte, carry in bit 0 |
| op_i | input | 3 | Operation code 0 to 7 |
| short_i | input | 1 | Short accumulator form select |
| result_o | output | 8 | Shifted or rotated byte |
| flags_o | output | 8 | Outgoing flag byte |

## Verification
Directed operands 00, 01, 80, 7F and FF are applied to every operation with carry in both 0 and 1. These values separate a bit filled with zero from one filled with the carry or the sign, and they drive the zero and parity flags to both extremes. Short-form cases use incoming S, Z and P/V values that disagree with what the result would give, so a pass-through cannot be mistaken for a recomputed flag. Shifts with short_i set, and op code 7, show whether the select or the unused code leaks into the outputs. Random operands, flags and codes then cover the mixed cases against bench models written as a doubled-word slice.

// File: rtl/shr_pkg.sv
package shr_pkg;
  localparam int unsigned DW    = 8;
  localparam int unsigned OPW   = 3;
  localparam int unsigned FLG_S = 7;
  localparam int unsigned FLG_Z = 6;
  localparam int unsigned FLG_H = 4;
  localparam int unsigned FLG_P = 2;
  localparam int unsigned FLG_N = 1;
  localparam int unsigned FLG_C = 0;

  typedef enum logic [OPW-1:0] {
    OP_ROL_CIRC = 3'd0,
    OP_ROR_CIRC = 3'd1,
    OP_ROL_CARRY = 3'd2,
    OP_ROR_CARRY = 3'd3,
    OP_SHL_ARITH = 3'd4,
    OP_SHR_ARITH = 3'd5,
    OP_SHR_LOGIC = 3'd6,
    OP_NONE = 3'd7
  } shr_op_e;

  typedef struct packed {
    logic [DW-1:0] res;
    logic          cout;
  } shr_out_t;

  function automatic logic even_parity(input logic [DW-1:0] v);
    return ~(^v);
  endfunction

  function automatic shr_out_t shift_one(input shr_op_e op, input logic [DW-1:0] a,
                                         input logic cin);
    shr_out_t o;
    logic     left;
    logic     fill;
    left = (op == OP_ROL_CIRC) || (op == OP_ROL_CARRY) || (op == OP_SHL_ARITH);
    unique case (op)
      OP_ROL_CIRC:  fill = a[DW-1];
      OP_ROR_CIRC:  fill = a[0];
      OP_ROL_CARRY, OP_ROR_CARRY: fill = cin;
      OP_SHR_ARITH: fill = a[DW-1];
      default:      fill = 1'b0;
    endcase
    if (left) begin
      o.res  = {a[DW-2:0], fill};
      o.cout = a[DW-1];
    end else begin
      o.res  = {fill, a[DW-1:1]};
      o.cout = a[0];
    end
    return o;
  endfunction
endpackage

// File: rtl/shr_core.sv
module shr_core
  import shr_pkg::*;
(
  input  logic [DW-1:0]  a_i,
  input  logic           cin_i,
  input  logic [OPW-1:0] op_i,
  output logic [DW-1:0]  res_o,
  output logic           cout_o,
  output logic           valid_o,
  output logic           rot_o
);
  shr_op_e  op_w;
  shr_out_t sh_w;

  assign op_w    = shr_op_e'(op_i);
  assign valid_o = (op_w != OP_NONE);
  assign rot_o   = (op_i[OPW-1] == 1'b0);

  always_comb begin
    sh_w = shift_one(op_w, a_i, cin_i);
    if (valid_o) begin
      res_o  = sh_w.res;
      cout_o = sh_w.cout;
    end else begin
      res_o  = a_i;
      cout_o = cin_i;
    end
  end
endmodule

// File: rtl/shr_flags.sv
module shr_flags
  import shr_pkg::*;
(
  input  logic [DW-1:0] res_i,
  input  logic          cout_i,
  input  logic [DW-1:0] flags_i,
  input  logic          valid_i,
  input  logic          keep_szp_i,
  output logic [DW-1:0] flags_o
);
  logic zero_w;
  logic par_w;

  assign zero_w = (res_i == '0);
  assign par_w  = even_parity(res_i);

  always_comb begin
    flags_o = flags_i;
    if (valid_i) begin
      flags_o[FLG_H] = 1'b0;
      flags_o[FLG_N] = 1'b0;
      flags_o[FLG_C] = cout_i;
      if (!keep_szp_i) begin
        flags_o[FLG_S] = res_i[DW-1];
        flags_o[FLG_Z] = zero_w;
        flags_o[FLG_P] = par_w;
      end
    end
  end
endmodule

// File: rtl/shr_unit.sv
module shr_unit
  import shr_pkg::*;
(
  input  logic [7:0] opnd_i,
  input  logic [7:0] flags_i,
  input  logic [2:0] op_i,
  input  logic       short_i,
  output logic [7:0] result_o,
  output logic [7:0] flags_o
);
  logic [DW-1:0] res_w;
  logic          cout_w;
  logic          op_valid_w;
  logic          rot_op_w;
  logic          short_act_w;

  shr_core u_core (
    .a_i     (opnd_i),
    .cin_i   (flags_i[FLG_C]),
    .op_i    (op_i),
    .res_o   (res_w),
    .cout_o  (cout_w),
    .valid_o (op_valid_w),
    .rot_o   (rot_op_w)
  );

  assign short_act_w = short_i && rot_op_w && op_valid_w;

  shr_flags u_flags (
    .res_i      (res_w),
    .cout_i     (cout_w),
    .flags_i    (flags_i),
    .valid_i    (op_valid_w),
    .keep_szp_i (short_act_w),
    .flags_o    (flags_o)
  );

  assign result_o = res_w;
endmodule

// File: rtl/shr_unit_chk.sv
module shr_unit_chk (
  input logic [7:0] opnd_i,
  input logic [7:0] flags_i,
  input logic [2:0] op_i,
  input logic       short_i,
  input logic [7:0] result_o,
  input logic [7:0] flags_o,
  input logic       short_act_w
);
  logic known_w;
  assign known_w = !$isunknown({opnd_i, flags_i, op_i, short_i});

  always @* begin
    if (known_w) begin
      if (op_i == 3'd7)
        AST_NONE_PASSES: assert (result_o == opnd_i && flags_o == flags_i); // R11
      if (op_i != 3'd7)
        AST_HN_CLEAR: assert (flags_o[4] == 1'b0 && flags_o[1] == 1'b0); // R8
      AST_SPARE_KEPT: assert (flags_o[5] == flags_i[5] && flags_o[3] == flags_i[3]); // R12
      if (short_act_w)
        AST_SHORT_SZP: assert (flags_o[7] == flags_i[7] && flags_o[6] == flags_i[6] && flags_o[2] == flags_i[2]); // R9
      if (op_i != 3'd7 && !short_act_w)
        AST_FULL_FLAGS: assert (flags_o[6] == (result_o == 8'h00) && flags_o[2] == ~(^result_o) && flags_o[7] == result_o[7]); // R8
      if (op_i == 3'd0)
        AST_CIRC_LEFT: assert (flags_o[0] == opnd_i[7] && result_o[0] == opnd_i[7]); // R1
      if (op_i[2] && op_i != 3'd7)
        AST_SHIFT_NO_SHORT: assert (!short_act_w); // R10
    end
  end
endmodule

bind shr_unit shr_unit_chk u_chk (
  .opnd_i      (opnd_i),
  .flags_i     (flags_i),
  .op_i        (op_i),
  .short_i     (short_i),
  .result_o    (result_o),
  .flags_o     (flags_o),
  .short_act_w (short_act_w)
);

// File: tb/test_shr_unit.sv
module test_shr_unit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] opnd_i = 8'h00;
  logic [7:0] flags_i = 8'h00;
  logic [2:0] op_i = 3'd7;
  logic       short_i = 1'b0;
  logic [7:0] result_o;
  logic [7:0] flags_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;

  shr_unit i_shr_unit (
    .opnd_i(opnd_i), .flags_i(flags_i), .op_i(op_i), .short_i(short_i),
    .result_o(result_o), .flags_o(flags_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000 && !done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: actual cycles %0d expected below 20000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  // Bench model: take a window out of a doubled 16-bit word.
  function automatic logic [8:0] model_shift(input logic [2:0] op, input logic [7:0] a,
                                             input logic c);
    logic [15:0] w;
    logic [7:0]  r;
    logic        co;
    case (op)
      3'd0: begin w = {a, a}; r = w[14:7]; co = a[7]; end
      3'd1: begin w = {a, a}; r = w[8:1];  co = a[0]; end
      3'd2: begin w = {7'd0, a, c};  r = w[7:0]; co = a[7]; end
      3'd3: begin w = {7'd0, c, a};  r = w[8:1]; co = a[0]; end
      3'd4: begin w = {7'd0, a, 1'b0}; r = w[7:0]; co = a[7]; end
      3'd5: begin w = {7'd0, a[7], a}; r = w[8:1]; co = a[0]; end
      3'd6: begin w = {8'd0, a};     r = w[8:1]; co = a[0]; end
      default: begin r = a; co = c; end
    endcase
    return {co, r};
  endfunction

  function automatic logic [15:0] model_all(input logic [2:0] op, input logic [7:0] a,
                                            input logic [7:0] f, input logic sh);
    logic [8:0] m;
    logic [7:0] fo;
    int         ones;
    m = model_shift(op, a, f[0]);
    if (op == 3'd7) return {a, f};
    ones = 0;
    for (int k = 0; k < 8; k++) ones += int'(m[k]);
    fo = f;
    fo[4] = 1'b0;
    fo[1] = 1'b0;
    fo[0] = m[8];
    if (!(sh && op < 3'd4)) begin
      fo[7] = m[7];
      fo[6] = (m[7:0] == 8'h00);
      fo[2] = (ones % 2 == 0);
    end
    return {m[7:0], fo};
  endfunction

  function automatic string req_of(input logic [2:0] op, input logic sh);
    case (op)
      3'd0: return sh ? "R9/R1" : "R1";
      3'd1: return sh ? "R9/R2" : "R2";
      3'd2: return sh ? "R9/R3" : "R3";
      3'd3: return sh ? "R9/R4" : "R4";
      3'd4: return sh ? "R10/R5" : "R5";
      3'd5: return sh ? "R10/R6" : "R6";
      3'd6: return sh ? "R10/R7" : "R7";
      default: return "R11";
    endcase
  endfunction

  task automatic apply(input logic [2:0] op, input logic [7:0] a, input logic [7:0] f,
                       input logic sh);
    logic [15:0] exp;
    @(posedge clk);
    opnd_i = a; flags_i = f; op_i = op; short_i = sh;
    @(negedge clk);
    exp = model_all(op, a, f, sh);
    n_chk++;
    if (result_o !== exp[15:8]) begin
      n_bad++;
      $display("FAIL %s result: op %0d a %h f %h: actual %h expected %h",
               req_of(op, sh), op, a, f, result_o, exp[15:8]);
    end
    n_chk++;
    if (flags_o !== exp[7:0]) begin
      n_bad++;
      $display("FAIL %s/R8/R12 flags: op %0d a %h f %h: actual %h expected %h",
               req_of(op, sh), op, a, f, flags_o, exp[7:0]);
    end
  endtask

  initial begin
    logic [7:0] corners [5];
    int unsigned seed;
    corners[0] = 8'h00; corners[1] = 8'h01; corners[2] = 8'h80;
    corners[3] = 8'h7F; corners[4] = 8'hFF;
    seed = 32'd1996;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // Idle state: op 7 with zero inputs must give zeros (R11)
    apply(3'd7, 8'h00, 8'h00, 1'b0);
    // Directed corners, all ops, both carry values, full form (R1-R7 tags below)
    for (int op = 0; op < 8; op++)
      for (int c = 0; c < 5; c++) begin
        apply(3'(op), corners[c], 8'h00, 1'b0);
        apply(3'(op), corners[c], 8'hFF, 1'b0);
        apply(3'(op), corners[c], 8'h29, 1'b0);
      end
    // R9: short rotates with incoming S/Z/PV opposite to the result's
    for (int op = 0; op < 4; op++)
      for (int c = 0; c < 5; c++) begin
        apply(3'(op), corners[c], 8'hC4, 1'b1);
        apply(3'(op), corners[c], 8'h3B, 1'b1);
      end
    // R10: short select on shifts has no effect; R11 with short set
    for (int op = 4; op < 8; op++)
      for (int c = 0; c < 5; c++)
        apply(3'(op), corners[c], 8'hC5, 1'b1);
    // Random mix covering R1..R12
    repeat (3000)
      apply(3'($urandom_range(0, 7)), 8'($urandom), 8'($urandom), 1'($urandom));
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule